// File: doc/BRIEF.md
# Key-Locked Control and Status Register Block

This block is a small register file on a plain 32-bit word bus. It holds four registers: a write-enable mask, a control word, a read-only status word and a lock register. The control word drives a set of single-bit control outputs. Software changes a control bit only if two things are true: the matching mask bit is set, and the block has been unlocked first.

The lock flag starts set. Writing a fixed 32-bit key to the lock register clears it. Writing the value one sets it again, and any other value leaves it as it is. The flag shows in the status word and in the lock register readback. Status flags from outside logic are registered on every clock edge. These cover scan-clear, calibration and memory-clear progress, together with three 3-bit fail vectors. The fail vectors are folded into an OR field and an AND field.

Reads are combinational from the address. Writes take effect on the rising clock edge.

Top module: `keyreg_ctrl`

## Requirements
- R1: After synchronous active-low reset the registers read as follows: mask reads 0x000001FE, control reads 0x000001FE, status reads 0x000000D7 and the lock register reads 0x00000001. These values hold until the first clock edge after reset is released.
- R2: A full-word write to offset 0xC with 0xF9E8D7C6 clears the lock flag. A write of 0x00000001 sets it, and any other value leaves it unchanged. Lock writes are accepted whether the block is locked or not.
- R3: While the lock flag is 1, writes to offsets 0x0 (mask) and 0x4 (control) change nothing.
- R4: An unlocked write to offset 0x4 sets control to (old & ~mask) | (wdata & mask) over bits 20..0.
- R5: An unlocked write to offset 0x0 stores wdata bits 20..0 into the mask. Bits 31..21 of both mask and control always read as zero.
- R6: Status (offset 0x8) is registered from the inputs on every clock edge with this layout:
  - bit 0: lock flag
  - bit 1: scan done
  - bit 2: scan pass
  - bit 3: in calibration
  - bit 4: calibration done
  - bit 5: calibration error
  - bit 6: memory done
  - bit 7: memory pass
  - bits 10..8: fail_a | fail_b | fail_c
  - bits 13..11: fail_a & fail_b & fail_c
  - bits 31..14: zero
- R7: Writes to the status offset have no effect.
- R8: Reading offset 0xC returns the lock flag in bit 0 and zero in all other bits.
- R9: Any address other than 0x0, 0x4, 0x8 and 0xC, including misaligned ones, reads as zero. Writes to such addresses have no effect.
- R10: A write whose byte enables are not all four set has no effect on any register.
- R11: The control output equals the stored control register bits 20..0.
- R12: Asserting reset in the middle of operation restores every register to its R1 value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | AW | Byte address of the access |
| bus_wr | input | 1 | Write strobe |
| bus_be | input | 4 | Byte enables; only 4'hF writes |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data for bus_addr |
| scan_done | input | 1 | Scan-clear finished |
| scan_pass | input | 1 | Scan-clear passed |
| in_cal | input | 1 | Calibration in progress |
| cal_done | input | 1 | Calibration finished |
| cal_err | input | 1 | Calibration error |
| mem_done | input | 1 | Memory-clear finished |
| mem_pass | input | 1 | Memory-clear passed |
| fail_a | input | FAIL_W | Fail vector A |
| fail_b | input | FAIL_W | Fail vector B |
| fail_c | input | FAIL_W | Fail vector C |
| ctrl_o | output | CTRL_W | Control register bits |

## Verification
The assertions check several rules on every cycle:
- While locked, the control and mask registers stay frozen.
- A control bit never changes unless its mask bit was set.
- The key and the value one drive the lock flag as described, and nothing else touches it.
- Partial-width writes leave all state alone.
- Reserved and unmapped read bits are zero.
- The fail fields follow the fail vectors one cycle later.

Only the bench scenarios show the rest. These are the exact reset values, the arithmetic result of masked writes over many mask and data pairs, the full status bit layout across every fail-vector combination, and that a mid-run reset restores everything.

// File: rtl/keyreg_ctrl.sv
module keyreg_ctrl #(
  parameter int          AW       = 8,
  parameter int          CTRL_W   = 21,
  parameter int          FAIL_W   = 3,
  parameter logic [31:0] KEY      = 32'hF9E8D7C6,
  parameter logic [31:0] CTRL_RST = 32'h0000_01FE
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [AW-1:0]     bus_addr,
  input  logic              bus_wr,
  input  logic [3:0]        bus_be,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic              scan_done,
  input  logic              scan_pass,
  input  logic              in_cal,
  input  logic              cal_done,
  input  logic              cal_err,
  input  logic              mem_done,
  input  logic              mem_pass,
  input  logic [FAIL_W-1:0] fail_a,
  input  logic [FAIL_W-1:0] fail_b,
  input  logic [FAIL_W-1:0] fail_c,
  output logic [CTRL_W-1:0] ctrl_o
);
  localparam int STAT_W = 8 + 2 * FAIL_W;
  localparam logic [AW-1:0] OFS_MASK = AW'(0);
  localparam logic [AW-1:0] OFS_CTRL = AW'(4);
  localparam logic [AW-1:0] OFS_STAT = AW'(8);
  localparam logic [AW-1:0] OFS_LOCK = AW'(12);
  localparam logic [STAT_W-1:1] STAT_RST = (STAT_W-1)'(7'b1101011);
  localparam logic [31:0] ONE = 32'h1;

  logic [CTRL_W-1:0] mask_q;
  logic [CTRL_W-1:0] ctrl_q;
  logic [STAT_W-1:1] stat_q;
  logic              lock_q;
  logic              wr_full;
  logic [CTRL_W-1:0] wd;

  assign wr_full = bus_wr && (bus_be == 4'hF);
  assign wd      = bus_wdata[CTRL_W-1:0];
  assign ctrl_o  = ctrl_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mask_q <= CTRL_RST[CTRL_W-1:0];
      ctrl_q <= CTRL_RST[CTRL_W-1:0];
      stat_q <= STAT_RST;
      lock_q <= 1'b1;
    end else begin
      stat_q <= {fail_a & fail_b & fail_c, fail_a | fail_b | fail_c,
                 mem_pass, mem_done, cal_err, cal_done, in_cal, scan_pass, scan_done};
      if (wr_full && !lock_q && bus_addr == OFS_MASK)
        mask_q <= wd;
      if (wr_full && !lock_q && bus_addr == OFS_CTRL)
        ctrl_q <= (ctrl_q & ~mask_q) | (wd & mask_q);
      if (wr_full && bus_addr == OFS_LOCK) begin
        if (bus_wdata == KEY)      lock_q <= 1'b0;
        else if (bus_wdata == ONE) lock_q <= 1'b1;
      end
    end
  end

  always_comb begin
    case (bus_addr)
      OFS_MASK: bus_rdata = {{(32-CTRL_W){1'b0}}, mask_q};
      OFS_CTRL: bus_rdata = {{(32-CTRL_W){1'b0}}, ctrl_q};
      OFS_STAT: bus_rdata = {{(32-STAT_W){1'b0}}, stat_q, lock_q};
      OFS_LOCK: bus_rdata = {31'b0, lock_q};
      default:  bus_rdata = 32'b0;
    endcase
  end
endmodule

// File: rtl/keyreg_ctrl_chk.sv
module keyreg_ctrl_chk #(
  parameter int          AW     = 8,
  parameter int          CTRL_W = 21,
  parameter int          FAIL_W = 3,
  parameter logic [31:0] KEY    = 32'hF9E8D7C6
) (
  input logic              clk,
  input logic              rst_n,
  input logic [AW-1:0]     bus_addr,
  input logic              bus_wr,
  input logic [3:0]        bus_be,
  input logic [31:0]       bus_wdata,
  input logic [31:0]       bus_rdata,
  input logic [FAIL_W-1:0] fail_a,
  input logic [FAIL_W-1:0] fail_b,
  input logic [FAIL_W-1:0] fail_c,
  input logic [CTRL_W-1:0] ctrl_o,
  input logic [CTRL_W-1:0] mask_q,
  input logic [8+2*FAIL_W-1:1] stat_q,
  input logic              lock_q
);
  logic lock_wr;
  logic mapped;
  assign lock_wr = bus_wr && bus_be == 4'hF && bus_addr == AW'(12);
  assign mapped  = bus_addr == AW'(0) || bus_addr == AW'(4) ||
                   bus_addr == AW'(8) || bus_addr == AW'(12);

  AST_LOCKED_CTRL_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    lock_q |=> $stable(ctrl_o)); // R3
  AST_LOCKED_MASK_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    lock_q |=> $stable(mask_q)); // R3
  AST_CTRL_ONLY_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((ctrl_o ^ $past(ctrl_o)) & ~$past(mask_q)) == '0); // R4
  AST_KEY_UNLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    (lock_wr && bus_wdata == KEY) |=> !lock_q); // R2
  AST_ONE_LOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    (lock_wr && bus_wdata == 32'h1) |=> lock_q); // R2
  AST_LOCK_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (!lock_wr || (bus_wdata != KEY && bus_wdata != 32'h1)) |=> $stable(lock_q)); // R2
  AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == AW'(0) || bus_addr == AW'(4)) |-> bus_rdata[31:CTRL_W] == '0); // R5
  AST_FAIL_OR: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> stat_q[8 +: FAIL_W] == $past(fail_a | fail_b | fail_c)); // R6
  AST_FAIL_AND: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> stat_q[8+FAIL_W +: FAIL_W] == $past(fail_a & fail_b & fail_c)); // R6
  AST_LOCK_READBACK: assert property (@(posedge clk) disable iff (!rst_n)
    bus_addr == AW'(12) |-> bus_rdata == {31'b0, lock_q}); // R8
  AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !mapped |-> bus_rdata == 32'b0); // R9
  AST_PARTIAL_NO_EFFECT: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_be != 4'hF) |=> $stable(ctrl_o) && $stable(mask_q) && $stable(lock_q)); // R10
endmodule

bind keyreg_ctrl keyreg_ctrl_chk #(.AW(AW), .CTRL_W(CTRL_W), .FAIL_W(FAIL_W), .KEY(KEY)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_be(bus_be),
  .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .fail_a(fail_a), .fail_b(fail_b),
  .fail_c(fail_c), .ctrl_o(ctrl_o), .mask_q(mask_q), .stat_q(stat_q), .lock_q(lock_q));

// File: tb/keyreg_ctrl_test.sv
module keyreg_ctrl_test;
  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] KEY = 32'hF9E8D7C6;
  localparam logic [31:0] M21 = 32'h001F_FFFF;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [7:0] bus_addr = '0;
  logic bus_wr = 1'b0;
  logic [3:0] bus_be = 4'hF;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic scan_done = 0, scan_pass = 0, in_cal = 0, cal_done = 0, cal_err = 0, mem_done = 0, mem_pass = 0;
  logic [2:0] fail_a = 0, fail_b = 0, fail_c = 0;
  logic [20:0] ctrl_o;

  int total = 0;
  int bad = 0;
  logic [31:0] lfsr = 32'h1ACE_B00C;
  logic [31:0] exp_ctrl, exp_mask, got;

  always #(CLK_PERIOD/2) clk = ~clk;

  keyreg_ctrl uut (.clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_be(bus_be), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .scan_done(scan_done),
    .scan_pass(scan_pass), .in_cal(in_cal), .cal_done(cal_done), .cal_err(cal_err),
    .mem_done(mem_done), .mem_pass(mem_pass), .fail_a(fail_a), .fail_b(fail_b),
    .fail_c(fail_c), .ctrl_o(ctrl_o));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d, input logic [3:0] be = 4'hF);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_be = be; bus_wr = 1'b1;
    @(posedge clk); #1;
    bus_wr = 1'b0; bus_be = 4'hF;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic step_lfsr();
    lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
  endtask

  task automatic check_regs(input string req, input logic [31:0] m, input logic [31:0] c, input logic lk);
    rd(8'h0, got);  chk(req, got, m);
    rd(8'h4, got);  chk(req, got, c);
    rd(8'hC, got);  chk(req, got, {31'b0, lk});
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    #1;
    // R1 reset values before the first post-reset edge
    bus_addr = 8'h0; #1 chk("R1 mask", bus_rdata, 32'h1FE);
    bus_addr = 8'h4; #1 chk("R1 ctrl", bus_rdata, 32'h1FE);
    bus_addr = 8'h8; #1 chk("R1 status", bus_rdata, 32'hD7);
    bus_addr = 8'hC; #1 chk("R1 lock", bus_rdata, 32'h1);
    chk("R11 ctrl_o at reset", {11'b0, ctrl_o}, 32'h1FE);

    // R3 locked writes ignored
    wr(8'h0, 32'hFFFF_FFFF);
    wr(8'h4, 32'h0);
    check_regs("R3 locked", 32'h1FE, 32'h1FE, 1'b1);

    // R2 lock value sweep
    wr(8'hC, KEY);
    rd(8'hC, got); chk("R2 key unlocks", got, 32'h0);
    for (int b = 0; b < 32; b++) begin
      wr(8'hC, KEY ^ (32'h1 << b));
      if ((KEY ^ (32'h1 << b)) != 32'h1) begin
        rd(8'hC, got); chk("R2 near-key keeps unlocked", got, 32'h0);
      end
    end
    wr(8'hC, 32'h2);
    rd(8'hC, got); chk("R2 value 2 ignored", got, 32'h0);
    wr(8'hC, 32'h1);
    rd(8'hC, got); chk("R2 one locks", got, 32'h1);
    wr(8'hC, 32'h0);
    rd(8'hC, got); chk("R2 zero ignored", got, 32'h1);
    wr(8'hC, 32'hFFFF_FFFF);
    rd(8'h8, got); chk("R2 status lock bit", got & 32'h1, 32'h1);
    wr(8'hC, KEY);
    rd(8'h8, got); chk("R8 status bit0 follows unlock", got & 32'h1, 32'h0);

    // R4 R5 R3 R11 masked-write sweep
    exp_mask = 32'h1FE; exp_ctrl = 32'h1FE;
    for (int i = 0; i < 300; i++) begin
      logic [31:0] m, d;
      step_lfsr(); m = lfsr;
      step_lfsr(); d = lfsr;
      if (i % 5 == 4) begin
        wr(8'hC, 32'h1);
        wr(8'h0, m); wr(8'h4, d);
        check_regs("R3 locked in sweep", exp_mask, exp_ctrl, 1'b1);
        wr(8'hC, KEY);
      end else begin
        wr(8'h0, m);
        exp_mask = m & M21;
        rd(8'h0, got); chk("R5 mask store and reserved zero", got, exp_mask);
        wr(8'h4, d);
        exp_ctrl = (exp_ctrl & ~exp_mask) | (d & exp_mask);
        rd(8'h4, got); chk("R4 masked ctrl write", got, exp_ctrl);
        chk("R11 ctrl_o", {11'b0, ctrl_o}, exp_ctrl);
      end
    end

    // R10 partial byte enables
    wr(8'h0, M21);
    exp_mask = M21;
    for (int be = 0; be < 15; be++) begin
      wr(8'h4, ~exp_ctrl, 4'(be));
      wr(8'h0, 32'h0, 4'(be));
      wr(8'hC, 32'h1, 4'(be));
      check_regs("R10 partial write", exp_mask, exp_ctrl, 1'b0);
    end

    // R7 status write ignored
    wr(8'h8, 32'hFFFF_FFFF);
    rd(8'h8, got); chk("R7 status write ignored", got, 32'h0);
    check_regs("R7 other regs", exp_mask, exp_ctrl, 1'b0);

    // R9 unmapped sweep
    for (int a = 0; a < 256; a++) begin
      if (a != 0 && a != 4 && a != 8 && a != 12) begin
        wr(8'(a), 32'h1);
        rd(8'(a), got); chk("R9 unmapped read zero", got, 32'h0);
      end
    end
    check_regs("R9 unmapped writes ignored", exp_mask, exp_ctrl, 1'b0);

    // R6 status layout sweep
    for (int v = 0; v < 512; v++) begin
      logic [2:0] a3, b3, c3;
      logic [31:0] e;
      @(negedge clk);
      a3 = 3'(v); b3 = 3'(v >> 3); c3 = 3'(v >> 6);
      fail_a = a3; fail_b = b3; fail_c = c3;
      {mem_pass, mem_done, cal_err, cal_done, in_cal, scan_pass, scan_done} = 7'(v * 37);
      e = {18'b0, a3 & b3 & c3, a3 | b3 | c3, 7'(v * 37), 1'b0};
      rd(8'h8, got); chk("R6 status layout", got, e);
    end

    // R12 mid-run reset
    wr(8'h4, 32'h0);
    @(negedge clk); rst_n = 1'b0;
    @(posedge clk); #1;
    @(negedge clk); rst_n = 1'b1;
    #1;
    bus_addr = 8'h8; #1 chk("R12 status after reset", bus_rdata, 32'hD7);
    check_regs("R12 regs after reset", 32'h1FE, 32'h1FE, 1'b1);
    chk("R12 ctrl_o after reset", {11'b0, ctrl_o}, 32'h1FE);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule